// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit carries out one atomic memory operation at a time for a 64-bit integer pipeline. It takes a decoded 32-bit instruction word, the base register value (the address) and the source register value (the operand). It then makes two passes over a single-port memory request/response interface. The first pass reads the target location into an internal holding register. The second pass combines that held value with the operand and writes the result back to the same address. The destination value it returns is the content of memory as it was before the update.

Both 32-bit and 64-bit accesses are supported. A 32-bit operation works only on the low half of the data bus. The value read back is sign-extended to 64 bits. Ordering hints from the instruction travel separately: the acquire hint goes out with the read request and the release hint goes out with the write request. An encoding the unit does not handle, or an address that is not naturally aligned, gives a one-cycle fault pulse and makes no memory access.

Top module: `amo_rmw_unit`

## Requirements
- R1: An instruction is legal only when instr[6:0] is 0x2F and instr[14:12] is 2 (32-bit access, mem_req_size 0) or 3 (64-bit access, mem_req_size 1).
- R2: instr[31:27] selects the operation. 0x00 add, 0x01 swap, 0x04 xor, 0x08 or, 0x0C and, 0x10 signed min, 0x14 signed max, 0x18 unsigned min, 0x1C unsigned max.
- R3: Both requests use rs1 unchanged as the address. The read is always issued first. The write to the same address is issued only after the read response has returned.
- R4: rd_value is the memory content seen by the read. For a 32-bit access it is the low 32 bits of the response, sign-extended to 64 bits.
- R5: The written value is rs2 + old, rs2, rs2 ^ old, rs2 | old or rs2 & old, as selected. For a 32-bit access, wdata[31:0] holds the 32-bit result and the upper half repeats bit 31.
- R6: Min and max compare at the selected width. The comparison is two's-complement for 0x10/0x14 and unsigned for 0x18/0x1C.
- R7: instr[26] (acquire) sets mem_req_acquire on the read request only. instr[25] (release) sets mem_req_release on the write request only.
- R8: Any other opcode, any funct3 other than 2 or 3, or any other funct5 (0x02 and 0x03 included) gives a one-cycle illegal pulse. No memory request is made and busy stays low.
- R9: A 32-bit access with rs1[1:0] != 0, or a 64-bit access with rs1[2:0] != 0, gives a one-cycle misaligned pulse. No memory request is made.
- R10: After reset, busy and done are low and req_ready is high. busy rises the cycle after a legal, aligned request is accepted and stays high until done. req_ready is low while busy, and any request offered while busy is ignored. done is a one-cycle pulse.
- R11: A memory request keeps valid, address and kind unchanged until mem_req_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Instruction offered |
| req_ready | output | 1 | Unit idle, instruction accepted this cycle if valid |
| instr | input | 32 | Instruction word |
| rs1 | input | XLEN | Address operand |
| rs2 | input | XLEN | Data operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_value | output | XLEN | Original memory value, valid with done |
| illegal | output | 1 | One-cycle unsupported-encoding pulse |
| misaligned | output | 1 | One-cycle alignment-fault pulse |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_write | output | 1 | 1 write, 0 read |
| mem_req_addr | output | XLEN | Request address |
| mem_req_wdata | output | XLEN | Write data |
| mem_req_size | output | 1 | 0 32-bit, 1 64-bit |
| mem_req_acquire | output | 1 | Acquire ordering tag |
| mem_req_release | output | 1 | Release ordering tag |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_rdata | input | XLEN | Read response data |

## Verification
Some properties are checked on every cycle:
- requests stay stable while stalled;
- every request address is aligned;
- the write goes to the address the read used;
- acquire never appears on a write and release never on a read;
- fault pulses never coincide with a memory request;
- completion only follows a response.

Other behaviour only the bench's scenarios can show: the arithmetic and comparison results at both widths, sign extension of the returned word, rejection of each unsupported encoding, and the fact that a request held high during an operation is ignored. The bench checks these against its own memory model.

// File: rtl/amo_pkg.sv
package amo_pkg;
  localparam logic [6:0] AMO_MAJOR   = 7'h2F;
  localparam logic [2:0] AMO_F3_WORD = 3'h2;
  localparam logic [2:0] AMO_F3_DBL  = 3'h3;

  typedef enum logic [3:0] {
    AMO_ADD, AMO_SWAP, AMO_XOR, AMO_OR, AMO_AND,
    AMO_MIN, AMO_MAX, AMO_MINU, AMO_MAXU
  } amo_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RREQ, ST_RRSP, ST_WREQ, ST_WRSP
  } amo_state_e;
endpackage

// File: rtl/amo_decode.sv
module amo_decode
  import amo_pkg::*;
(
  input  logic [4:0] funct5,
  input  logic [2:0] funct3,
  input  logic [6:0] opcode,
  input  logic [2:0] addr_lo,
  output logic       legal,
  output amo_op_e    op,
  output logic       is_word,
  output logic       aligned
);
  logic op_known;

  always_comb begin
    op_known = 1'b1;
    op       = AMO_ADD;
    case (funct5)
      5'h00: op = AMO_ADD;
      5'h01: op = AMO_SWAP;
      5'h04: op = AMO_XOR;
      5'h08: op = AMO_OR;
      5'h0C: op = AMO_AND;
      5'h10: op = AMO_MIN;
      5'h14: op = AMO_MAX;
      5'h18: op = AMO_MINU;
      5'h1C: op = AMO_MAXU;
      default: op_known = 1'b0;
    endcase
  end

  assign is_word = (funct3 == AMO_F3_WORD);
  assign legal   = op_known && (opcode == AMO_MAJOR) &&
                   (funct3 == AMO_F3_WORD || funct3 == AMO_F3_DBL);
  assign aligned = is_word ? (addr_lo[1:0] == 2'b00) : (addr_lo == 3'b000);
endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  amo_op_e         op,
  input  logic            is_word,
  input  logic [XLEN-1:0] mem_val,
  input  logic [XLEN-1:0] operand,
  output logic [XLEN-1:0] result
);
  localparam int HALF = XLEN / 2;

  logic            signed_cmp;
  logic [XLEN-1:0] a, b, raw;
  logic            a_lt_b;

  always_comb begin
    signed_cmp = (op == AMO_MIN) || (op == AMO_MAX);
    if (is_word) begin
      a = signed_cmp ? {{HALF{mem_val[HALF-1]}}, mem_val[HALF-1:0]}
                     : {{HALF{1'b0}}, mem_val[HALF-1:0]};
      b = signed_cmp ? {{HALF{operand[HALF-1]}}, operand[HALF-1:0]}
                     : {{HALF{1'b0}}, operand[HALF-1:0]};
    end else begin
      a = mem_val;
      b = operand;
    end
    a_lt_b = signed_cmp ? ($signed(a) < $signed(b)) : (a < b);
    case (op)
      AMO_ADD:             raw = a + b;
      AMO_SWAP:            raw = b;
      AMO_XOR:             raw = a ^ b;
      AMO_OR:              raw = a | b;
      AMO_AND:             raw = a & b;
      AMO_MIN, AMO_MINU:   raw = a_lt_b ? a : b;
      AMO_MAX, AMO_MAXU:   raw = a_lt_b ? b : a;
      default:             raw = b;
    endcase
    result = is_word ? {{HALF{raw[HALF-1]}}, raw[HALF-1:0]} : raw;
  end
endmodule

// File: rtl/amo_rmw_unit.sv
module amo_rmw_unit
  import amo_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [31:0]     instr,
  input  logic [XLEN-1:0] rs1,
  input  logic [XLEN-1:0] rs2,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] rd_value,
  output logic            illegal,
  output logic            misaligned,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic            mem_req_write,
  output logic [XLEN-1:0] mem_req_addr,
  output logic [XLEN-1:0] mem_req_wdata,
  output logic            mem_req_size,
  output logic            mem_req_acquire,
  output logic            mem_req_release,
  input  logic            mem_rsp_valid,
  input  logic [XLEN-1:0] mem_rsp_rdata
);
  localparam int HALF = XLEN / 2;

  amo_state_e      state;
  amo_op_e         op_q, dec_op;
  logic            word_q, acq_q, rel_q;
  logic [XLEN-1:0] addr_q, rs2_q, tmp_q, wdata_q, alu_out;
  logic            dec_legal, dec_word, dec_aligned;
  logic            unused_instr_bits;

  assign unused_instr_bits = ^{instr[24:15], instr[11:7]};

  amo_decode u_dec (
    .funct5  (instr[31:27]),
    .funct3  (instr[14:12]),
    .opcode  (instr[6:0]),
    .addr_lo (rs1[2:0]),
    .legal   (dec_legal),
    .op      (dec_op),
    .is_word (dec_word),
    .aligned (dec_aligned)
  );

  amo_alu #(.XLEN(XLEN)) u_alu (
    .op      (op_q),
    .is_word (word_q),
    .mem_val (mem_rsp_rdata),
    .operand (rs2_q),
    .result  (alu_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      op_q       <= AMO_ADD;
      word_q     <= 1'b0;
      acq_q      <= 1'b0;
      rel_q      <= 1'b0;
      addr_q     <= '0;
      rs2_q      <= '0;
      tmp_q      <= '0;
      wdata_q    <= '0;
      rd_value   <= '0;
      done       <= 1'b0;
      illegal    <= 1'b0;
      misaligned <= 1'b0;
    end else begin
      done       <= 1'b0;
      illegal    <= 1'b0;
      misaligned <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          if (!dec_legal) begin
            illegal <= 1'b1;
          end else if (!dec_aligned) begin
            misaligned <= 1'b1;
          end else begin
            op_q   <= dec_op;
            word_q <= dec_word;
            acq_q  <= instr[26];
            rel_q  <= instr[25];
            addr_q <= rs1;
            rs2_q  <= rs2;
            state  <= ST_RREQ;
          end
        end
        ST_RREQ: if (mem_req_ready) state <= ST_RRSP;
        ST_RRSP: if (mem_rsp_valid) begin
          tmp_q   <= mem_rsp_rdata;
          wdata_q <= alu_out;
          state   <= ST_WREQ;
        end
        ST_WREQ: if (mem_req_ready) state <= ST_WRSP;
        ST_WRSP: if (mem_rsp_valid) begin
          done     <= 1'b1;
          rd_value <= word_q ? {{HALF{tmp_q[HALF-1]}}, tmp_q[HALF-1:0]} : tmp_q;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy            = (state != ST_IDLE);
  assign req_ready       = (state == ST_IDLE);
  assign mem_req_valid   = (state == ST_RREQ) || (state == ST_WREQ);
  assign mem_req_write   = (state == ST_WREQ);
  assign mem_req_addr    = addr_q;
  assign mem_req_wdata   = wdata_q;
  assign mem_req_size    = ~word_q;
  assign mem_req_acquire = (state == ST_RREQ) && acq_q;
  assign mem_req_release = (state == ST_WREQ) && rel_q;

  // Address of the last accepted read, kept for the checks below
  logic [XLEN-1:0] chk_rd_addr;
  always_ff @(posedge clk) begin
    if (rst) chk_rd_addr <= '0;
    else if (mem_req_valid && mem_req_ready && !mem_req_write) chk_rd_addr <= mem_req_addr;
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write))) // R11
    else $error("request dropped or changed while stalled");
  AST_REQ_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> (mem_req_size ? (mem_req_addr[2:0] == 3'b000) : (mem_req_addr[1:0] == 2'b00))) // R9
    else $error("unaligned memory request");
  AST_WRITE_SAME_ADDR: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_write) |-> (mem_req_addr == chk_rd_addr)) // R3
    else $error("write address differs from read address");
  AST_TAG_SPLIT: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !(mem_req_write ? mem_req_acquire : mem_req_release)) // R7
    else $error("ordering tag on wrong phase");
  AST_FAULT_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
    (illegal || misaligned) |-> (!mem_req_valid && !busy)) // R8
    else $error("fault pulse during memory activity");
  AST_DONE_AFTER_RSP: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(mem_rsp_valid)) // R10
    else $error("done without a memory response");
  AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, illegal, misaligned})) // R10
    else $error("completion and fault pulses overlap");
endmodule

// File: tb/sim_amo_rmw_unit.sv
`timescale 1ns/1ps
module sim_amo_rmw_unit;
  localparam int XLEN = 64;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst, req_valid, req_ready, busy, done, illegal, misaligned;
  logic [31:0]     instr;
  logic [XLEN-1:0] rs1, rs2, rd_value;
  logic            mem_req_valid, mem_req_ready, mem_req_write, mem_req_size;
  logic            mem_req_acquire, mem_req_release, mem_rsp_valid;
  logic [XLEN-1:0] mem_req_addr, mem_req_wdata, mem_rsp_rdata;

  amo_rmw_unit #(.XLEN(XLEN)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .instr(instr), .rs1(rs1), .rs2(rs2), .busy(busy), .done(done),
    .rd_value(rd_value), .illegal(illegal), .misaligned(misaligned),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_req_size(mem_req_size),
    .mem_req_acquire(mem_req_acquire), .mem_req_release(mem_req_release),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  int checks = 0, failures = 0;
  logic [63:0] exp_q[$];
  logic [63:0] mon_exp;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [63:0] mem [0:15];
  logic        stall;
  int          rd_count, wr_count;
  logic        last_rd_acq, last_rd_rel, last_wr_acq, last_wr_rel, last_rd_size, last_wr_size;
  logic [63:0] last_rd_addr, last_wr_addr;

  assign mem_req_ready = ~stall;

  always @(posedge clk) begin
    if (rst) begin
      stall         <= 1'b1;
      mem_rsp_valid <= 1'b0;
      mem_rsp_rdata <= '0;
      rd_count      <= 0;
      wr_count      <= 0;
      for (int i = 0; i < 16; i++)
        mem[i] <= (64'hF0E1_D2C3_8000_0005 + 64'h0101_0101_0101_0101 * i) ^
                  ((i % 2 == 1) ? 64'h8000_0000_8000_0000 : 64'h0);
    end else begin
      stall         <= ~stall;
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        mem_rsp_valid <= 1'b1;
        if (mem_req_write) begin
          wr_count     <= wr_count + 1;
          last_wr_acq  <= mem_req_acquire;
          last_wr_rel  <= mem_req_release;
          last_wr_addr <= mem_req_addr;
          last_wr_size <= mem_req_size;
          if (mem_req_size) mem[mem_req_addr[6:3]] <= mem_req_wdata;
          else if (mem_req_addr[2]) mem[mem_req_addr[6:3]][63:32] <= mem_req_wdata[31:0];
          else mem[mem_req_addr[6:3]][31:0] <= mem_req_wdata[31:0];
        end else begin
          rd_count     <= rd_count + 1;
          last_rd_acq  <= mem_req_acquire;
          last_rd_rel  <= mem_req_release;
          last_rd_addr <= mem_req_addr;
          last_rd_size <= mem_req_size;
          if (mem_req_size) mem_rsp_rdata <= mem[mem_req_addr[6:3]];
          else mem_rsp_rdata <= {32'hDEAD_BEEF,
            (mem_req_addr[2] ? mem[mem_req_addr[6:3]][63:32] : mem[mem_req_addr[6:3]][31:0])};
        end
      end
    end
  end

  // ---------------- reference model ----------------
  function automatic logic [31:0] mk(input logic [4:0] f5, input bit aq, input bit rl,
                                     input logic [2:0] f3, input logic [6:0] opc);
    return {f5, aq, rl, 5'd2, 5'd1, f3, 5'd3, opc};
  endfunction

  function automatic logic [63:0] ref_new(input logic [4:0] f5, input bit word,
                                          input logic [63:0] o, input logic [63:0] s);
    logic [31:0] a32, b32, r32;
    logic [63:0] r64;
    a32 = o[31:0]; b32 = s[31:0]; r32 = 32'h0; r64 = 64'h0;
    if (word) begin
      case (f5)
        5'h00: r32 = a32 + b32;
        5'h01: r32 = b32;
        5'h04: r32 = a32 ^ b32;
        5'h08: r32 = a32 | b32;
        5'h0C: r32 = a32 & b32;
        5'h10: r32 = ($signed(a32) < $signed(b32)) ? a32 : b32;
        5'h14: r32 = ($signed(a32) > $signed(b32)) ? a32 : b32;
        5'h18: r32 = (a32 < b32) ? a32 : b32;
        default: r32 = (a32 > b32) ? a32 : b32;
      endcase
      return {{32{r32[31]}}, r32};
    end
    case (f5)
      5'h00: r64 = o + s;
      5'h01: r64 = s;
      5'h04: r64 = o ^ s;
      5'h08: r64 = o | s;
      5'h0C: r64 = o & s;
      5'h10: r64 = ($signed(o) < $signed(s)) ? o : s;
      5'h14: r64 = ($signed(o) > $signed(s)) ? o : s;
      5'h18: r64 = (o < s) ? o : s;
      default: r64 = (o > s) ? o : s;
    endcase
    return r64;
  endfunction

  // ---------------- monitor ----------------
  always @(negedge clk) begin
    if (!rst && done) begin
      if (exp_q.size() == 0) chk(1'b0, "R4 done with nothing pending", rd_value, 64'h0);
      else begin
        mon_exp = exp_q.pop_front();
        chk(rd_value == mon_exp, "R4 destination value", rd_value, mon_exp);
      end
    end
  end

  // ---------------- driver ----------------
  task automatic run_op(input logic [4:0] f5, input bit word, input bit aq, input bit rl,
                        input logic [63:0] addr, input logic [63:0] src, input bit hammer,
                        input string tag);
    logic [63:0] old_d, old, newv, new_d;
    logic [31:0] half;
    bit          stray;
    old_d = mem[addr[6:3]];
    half  = addr[2] ? old_d[63:32] : old_d[31:0];
    old   = word ? {{32{half[31]}}, half} : old_d;
    newv  = ref_new(f5, word, old, src);
    new_d = !word ? newv : (addr[2] ? {newv[31:0], old_d[31:0]} : {old_d[63:32], newv[31:0]});
    exp_q.push_back(old);
    @(negedge clk);
    req_valid = 1'b1;
    instr = mk(f5, aq, rl, word ? 3'h2 : 3'h3, 7'h2F);
    rs1 = addr; rs2 = src;
    @(posedge clk);
    @(negedge clk);
    chk(busy && !req_ready, "R10 busy after accept", {62'h0, busy, req_ready}, 64'h2);
    if (hammer) begin
      instr = mk(5'h05, 1'b0, 1'b0, 3'h3, 7'h2F);
      rs1 = 64'h3;
    end else req_valid = 1'b0;
    stray = 1'b0;
    while (!done) begin
      if (illegal || misaligned || req_ready) stray = 1'b1;
      @(negedge clk);
    end
    req_valid = 1'b0;
    if (hammer) chk(!stray, "R10 request ignored while busy", {63'h0, stray}, 64'h0);
    chk(mem[addr[6:3]] == new_d, {tag, " memory after update"}, mem[addr[6:3]], new_d);
    chk(last_rd_addr == addr && last_wr_addr == addr, "R3 address is rs1", last_wr_addr, addr);
    chk(last_rd_size == !word && last_wr_size == !word, "R1 access size",
        {63'h0, last_wr_size}, {63'h0, !word});
    chk({last_rd_acq, last_rd_rel, last_wr_acq, last_wr_rel} == {aq, 1'b0, 1'b0, rl},
        "R7 ordering tags", {60'h0, last_rd_acq, last_rd_rel, last_wr_acq, last_wr_rel},
        {60'h0, aq, 1'b0, 1'b0, rl});
    @(negedge clk);
    chk(!done && !busy, "R10 done is one cycle", {62'h0, done, busy}, 64'h0);
  endtask

  task automatic run_bad(input logic [31:0] ins, input logic [63:0] addr, input bit exp_ill,
                         input string tag);
    int rc, wc;
    rc = rd_count; wc = wr_count;
    @(negedge clk);
    req_valid = 1'b1; instr = ins; rs1 = addr; rs2 = 64'h55;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(illegal == exp_ill && misaligned == !exp_ill && !busy, {tag, " fault pulse"},
        {61'h0, illegal, misaligned, busy}, {61'h0, exp_ill, !exp_ill, 1'b0});
    @(negedge clk);
    chk(!illegal && !misaligned, {tag, " pulse one cycle"}, {62'h0, illegal, misaligned}, 64'h0);
    repeat (4) @(negedge clk);
    chk(rd_count == rc && wr_count == wc && !mem_req_valid, {tag, " no memory access"},
        64'(rd_count + wr_count), 64'(rc + wc));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL R10 watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    rst = 1'b1; req_valid = 1'b0; instr = '0; rs1 = '0; rs2 = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && req_ready && !done && !mem_req_valid && !illegal && !misaligned,
        "R10 reset state", {59'h0, busy, req_ready, done, mem_req_valid, illegal}, 64'h8);

    // R2 / R5: 64-bit arithmetic and logic
    run_op(5'h00, 1'b0, 1'b0, 1'b0, 64'h08, 64'h0000_0001_0000_0010, 1'b0, "R5 add64");
    run_op(5'h01, 1'b0, 1'b1, 1'b0, 64'h10, 64'h1234_5678_9ABC_DEF0, 1'b0, "R5 swap64");
    run_op(5'h04, 1'b0, 1'b0, 1'b1, 64'h18, 64'hFFFF_0000_FFFF_0000, 1'b0, "R5 xor64");
    run_op(5'h08, 1'b0, 1'b1, 1'b1, 64'h20, 64'h0000_00F0_0000_000F, 1'b0, "R5 or64");
    run_op(5'h0C, 1'b0, 1'b0, 1'b0, 64'h28, 64'h0F0F_0F0F_0F0F_0F0F, 1'b1, "R5 and64");
    // R6: 64-bit min/max, negative memory at index 0 vs positive operand
    run_op(5'h10, 1'b0, 1'b0, 1'b0, 64'h00, 64'h0000_0000_0000_0007, 1'b0, "R6 min64");
    run_op(5'h14, 1'b0, 1'b0, 1'b0, 64'h30, 64'h0000_0000_0000_0007, 1'b0, "R6 max64");
    run_op(5'h18, 1'b0, 1'b0, 1'b0, 64'h40, 64'h0000_0000_0000_0007, 1'b0, "R6 minu64");
    run_op(5'h1C, 1'b0, 1'b0, 1'b0, 64'h48, 64'h0000_0000_0000_0007, 1'b0, "R6 maxu64");
    // R4 / R5: 32-bit on both halves, negative values show sign extension
    run_op(5'h00, 1'b1, 1'b0, 1'b0, 64'h50, 64'hAAAA_AAAA_0000_0003, 1'b0, "R5 add32 low");
    run_op(5'h00, 1'b1, 1'b1, 1'b0, 64'h54, 64'h0000_0000_7FFF_FFFF, 1'b0, "R5 add32 high");
    run_op(5'h01, 1'b1, 1'b0, 1'b1, 64'h5C, 64'h0000_0000_8000_0001, 1'b0, "R5 swap32");
    // R6: 32-bit signed vs unsigned on the same data
    run_op(5'h01, 1'b1, 1'b0, 1'b0, 64'h60, 64'h0000_0000_8000_0000, 1'b0, "R5 setup32");
    run_op(5'h10, 1'b1, 1'b0, 1'b0, 64'h60, 64'h0000_0000_0000_0001, 1'b0, "R6 min32 signed");
    run_op(5'h01, 1'b1, 1'b0, 1'b0, 64'h64, 64'h0000_0000_8000_0000, 1'b0, "R5 setup32b");
    run_op(5'h18, 1'b1, 1'b0, 1'b0, 64'h64, 64'h0000_0000_0000_0001, 1'b0, "R6 minu32");
    run_op(5'h14, 1'b1, 1'b0, 1'b0, 64'h68, 64'hFFFF_FFFF_0000_0002, 1'b0, "R6 max32");
    run_op(5'h1C, 1'b1, 1'b0, 1'b0, 64'h6C, 64'h0000_0000_FFFF_FFFE, 1'b0, "R6 maxu32");
    run_op(5'h04, 1'b1, 1'b0, 1'b0, 64'h70, 64'h0000_0000_FFFF_FFFF, 1'b0, "R5 xor32");

    // R8: rejected encodings
    run_bad(mk(5'h02, 1'b0, 1'b0, 3'h3, 7'h2F), 64'h08, 1'b1, "R8 reserve-load form");
    run_bad(mk(5'h03, 1'b0, 1'b0, 3'h2, 7'h2F), 64'h08, 1'b1, "R8 cond-store form");
    run_bad(mk(5'h05, 1'b0, 1'b0, 3'h3, 7'h2F), 64'h08, 1'b1, "R8 unknown funct5");
    run_bad(mk(5'h00, 1'b0, 1'b0, 3'h1, 7'h2F), 64'h08, 1'b1, "R1 bad funct3");
    run_bad(mk(5'h00, 1'b0, 1'b0, 3'h3, 7'h33), 64'h08, 1'b1, "R1 bad opcode");
    // R9: misaligned addresses
    run_bad(mk(5'h00, 1'b0, 1'b0, 3'h2, 7'h2F), 64'h52, 1'b0, "R9 word off by 2");
    run_bad(mk(5'h00, 1'b0, 1'b0, 3'h3, 7'h2F), 64'h54, 1'b0, "R9 dword on 4");

    // operation after faults still works
    run_op(5'h00, 1'b0, 1'b1, 1'b1, 64'h78, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, "R5 add64 after faults");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R4 every operation completed", 64'(exp_q.size()), 64'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule